// File: doc/BRIEF.md
# Receive Address and Multicast Hash Filter

This block decides, for each incoming destination address, whether the frame is kept. It compares the 48-bit address against a bank of exact-match station entries and, for group addresses, looks up one bit of a 4096-bit hash table organised as 128 words of 32 bits. The result carries the accept decision, whether an exact entry matched, the number of the lowest matching entry and that entry's pool field. A broadcast control input decides whether the all-ones address is kept.

Software programs an entry through one write port, one 32-bit half per write. The low half holds address bytes 0 to 3 in little-endian order, with byte 0 in bits 7:0. The high half holds bytes 4 and 5, a pool field and a valid bit. A second write port sets single bits of the hash table. A two-bit mode input picks which 12 of the upper address bits form the hash index. Address byte k occupies `lk_addr[8k+7:8k]`, so byte 0 is `lk_addr[7:0]`, and bytes 4 and 5 form address bits 32 to 47.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset, res_valid is low, every hash bit is clear, and entries 1 to N_ENTRIES-1 are invalid. Entry 0 holds STATION_ADDR with pool 0, and it is valid only if STATION_ADDR is a station address. A station address has address bit 0 clear (not a group address), is not all ones and is not all zeros.
- R2: In an entry's low half (ent_hi=0), bits 31:0 hold address bytes 3,2,1,0, with byte 0 in bits 7:0. In its high half (ent_hi=1), bits 15:0 hold bytes 5,4, with byte 4 in bits 7:0. An entry matches only when all 48 bits are equal.
- R3: An entry takes part in matching only while bit 31 of its high half is set.
- R4: On an exact hit, res_pool reports bits 23:18 of the matching entry's high half.
- R5: When several valid entries match, res_index reports the lowest-numbered one.
- R6: hash_mode selects the 12-bit hash index: 0 takes address bits 47:36, 1 takes bits 46:35, 2 takes bits 45:34 and 3 takes bits 43:32.
- R7: A write of hash_vec sets bit hash_vec[4:0] of table word hash_vec[11:5] and leaves every other bit of the table unchanged.
- R8: A group address (bit 0 set) that is not broadcast is accepted when its hash bit is set. A station address is never accepted through the hash table.
- R9: The all-ones address is accepted when bcast_en is high or when an exact entry matches. Its hash bit has no effect.
- R10: A lookup presented at a clock edge gives res_valid and its results at the second edge after it, and res_valid stays low at the first edge. An entry or hash write at one edge is seen by lookups presented at the next edge or later.
- R11: While res_valid is low, res_accept and res_hit are low. When res_hit is low, res_index and res_pool are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_we | input | 1 | Entry half write strobe |
| ent_sel | input | IDX_W | Entry number to write |
| ent_hi | input | 1 | 0 writes the low half, 1 writes the high half |
| ent_data | input | 32 | Entry half write data |
| hash_we | input | 1 | Hash bit set strobe |
| hash_vec | input | 12 | Hash bit to set (word in bits 11:5, bit in 4:0) |
| hash_mode | input | 2 | Address window used for the hash index |
| bcast_en | input | 1 | Accept the all-ones address |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 48 | Destination address to test |
| res_valid | output | 1 | Lookup result present |
| res_accept | output | 1 | Frame is kept |
| res_hit | output | 1 | An exact entry matched |
| res_index | output | IDX_W | Lowest matching entry |
| res_pool | output | POOL_W | Pool field of that entry |

## Verification
Each lookup is presented in one cycle and withdrawn in the next. The bench samples the outputs on the falling edge after the second rising edge, where R10 places them. On the falling edge in between it checks that res_valid is still low. Writes are applied one cycle before the lookup that depends on them, which is the earliest slot R10 allows. Lookups are issued one at a time, so each sampled result can belong to only one request.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int MAC_W  = 48;
  localparam int HASH_W = 12;

  typedef logic [MAC_W-1:0] mac_t;

  // Station address: not a group address, not broadcast, not zero.
  function automatic logic is_station(mac_t a);
    return !a[0] && (a != {MAC_W{1'b1}}) && (a != '0);
  endfunction

  function automatic logic [HASH_W-1:0] hash_pick(mac_t a, logic [1:0] mode);
    logic [HASH_W-1:0] v;
    case (mode)
      2'd0:    v = a[47:36];
      2'd1:    v = a[46:35];
      2'd2:    v = a[45:34];
      default: v = a[43:32];
    endcase
    return v;
  endfunction

endpackage

// File: rtl/rxf_entry_bank.sv
module rxf_entry_bank
  import rxf_pkg::*;
#(
  parameter int   N_ENTRIES    = 16,
  parameter int   POOL_W       = 6,
  parameter int   POOL_LSB     = 18,
  parameter int   VALID_BIT    = 31,
  parameter mac_t STATION_ADDR = 48'h5544_3322_1102,
  localparam int  IDX_W        = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic              whi,
  input  logic [31:0]       wdata,
  input  logic              lk_valid,
  input  mac_t              lk_addr,
  output logic              s1_hit,
  output logic [IDX_W-1:0]  s1_idx,
  output logic [POOL_W-1:0] s1_pool
);

  localparam logic [31:0] RST_LO = STATION_ADDR[31:0];
  localparam logic [31:0] RST_HI =
    (32'(is_station(STATION_ADDR)) << VALID_BIT) | {16'h0, STATION_ADDR[47:32]};

  logic [31:0] lo_q [N_ENTRIES];
  logic [31:0] hi_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0] sel;
  logic any_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        lo_q[i] <= (i == 0) ? RST_LO : 32'h0;
        hi_q[i] <= (i == 0) ? RST_HI : 32'h0;
      end
    end else if (we && (int'(widx) < N_ENTRIES)) begin
      if (whi) hi_q[widx] <= wdata;
      else     lo_q[widx] <= wdata;
    end
  end

  for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_cmp
    assign hit_vec[gi] = hi_q[gi][VALID_BIT] && ({hi_q[gi][15:0], lo_q[gi]} == lk_addr);

    if (gi > 0) begin : g_chk
      AST_ENTRY_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !hi_q[gi][VALID_BIT]); // R1
    end
  end

  // Lowest-numbered valid match wins.
  always_comb begin
    sel     = '0;
    any_hit = 1'b0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel     = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_hit  <= 1'b0;
      s1_idx  <= '0;
      s1_pool <= '0;
    end else begin
      s1_hit  <= lk_valid && any_hit;
      s1_idx  <= (lk_valid && any_hit) ? sel : '0;
      s1_pool <= (lk_valid && any_hit) ? hi_q[sel][POOL_LSB +: POOL_W] : '0;
    end
  end

  AST_HIT_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !s1_hit); // R10

endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table #(
  parameter int  WORDS  = 128,
  parameter int  WORD_W = 32,
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int HIDX_W = BIT_W + WSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [HIDX_W-1:0] set_vec,
  input  logic              rd_en,
  input  logic [HIDX_W-1:0] rd_vec,
  output logic              rd_bit
);

  logic [WORD_W-1:0] mem [WORDS];

  logic [WSEL_W-1:0] set_w, rd_w;
  logic [BIT_W-1:0]  set_b, rd_b;

  assign set_w = set_vec[HIDX_W-1:BIT_W];
  assign set_b = set_vec[BIT_W-1:0];
  assign rd_w  = rd_vec[HIDX_W-1:BIT_W];
  assign rd_b  = rd_vec[BIT_W-1:0];

  // Read-modify-write of one word: OR in the new bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (set_en) begin
      mem[set_w] <= mem[set_w] | (WORD_W'(1) << set_b);
    end
  end

  // Registered lookup; reads the contents before a same-edge write.
  always_ff @(posedge clk) begin
    if (rst) rd_bit <= 1'b0;
    else     rd_bit <= rd_en && mem[rd_w][rd_b];
  end

  AST_HASH_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
    set_en |=> mem[$past(set_w)][$past(set_b)]); // R7

  AST_HASH_OR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((mem[$past(set_w)] & $past(mem[set_w])) == $past(mem[set_w]))); // R7

  for (genvar gw = 0; gw < WORDS; gw++) begin : g_rchk
    AST_HASH_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (mem[gw] == '0)); // R1
  end

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide #(
  parameter int IDX_W  = 4,
  parameter int POOL_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic              s1_group,
  input  logic              s1_bcast,
  input  logic              s1_bcen,
  input  logic              s1_hash_bit,
  input  logic              s1_hit,
  input  logic [IDX_W-1:0]  s1_idx,
  input  logic [POOL_W-1:0] s1_pool,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_index,
  output logic [POOL_W-1:0] res_pool
);

  logic via_hash, via_bcast;

  assign via_hash  = s1_group && !s1_bcast && s1_hash_bit;
  assign via_bcast = s1_bcast && s1_bcen;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_hit    <= 1'b0;
      res_index  <= '0;
      res_pool   <= '0;
    end else begin
      res_valid  <= s1_valid;
      res_accept <= s1_valid && (s1_hit || via_hash || via_bcast);
      res_hit    <= s1_valid && s1_hit;
      res_index  <= (s1_valid && s1_hit) ? s1_idx : '0;
      res_pool   <= (s1_valid && s1_hit) ? s1_pool : '0;
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> res_valid); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_accept && !res_hit)); // R11

  AST_STATION_NO_HASH: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_accept && !res_hit) |-> $past(s1_group)); // R8

  AST_MISS_FIELDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !res_hit |-> (res_index == '0 && res_pool == '0)); // R11

endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
  import rxf_pkg::*;
#(
  parameter int   N_ENTRIES    = 16,
  parameter int   POOL_W       = 6,
  parameter int   POOL_LSB     = 18,
  parameter int   VALID_BIT    = 31,
  parameter int   HT_WORDS     = 128,
  parameter int   HT_WORD_W    = 32,
  parameter mac_t STATION_ADDR = 48'h5544_3322_1102,
  localparam int  IDX_W        = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ent_we,
  input  logic [IDX_W-1:0]  ent_sel,
  input  logic              ent_hi,
  input  logic [31:0]       ent_data,
  input  logic              hash_we,
  input  logic [11:0]       hash_vec,
  input  logic [1:0]        hash_mode,
  input  logic              bcast_en,
  input  logic              lk_valid,
  input  logic [47:0]       lk_addr,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_index,
  output logic [POOL_W-1:0] res_pool
);

  localparam int HIDX_W = $clog2(HT_WORDS) + $clog2(HT_WORD_W);

  logic              s1_valid, s1_group, s1_bcast, s1_bcen;
  logic              s1_hash_bit, s1_hit;
  logic [IDX_W-1:0]  s1_idx;
  logic [POOL_W-1:0] s1_pool;
  logic [HIDX_W-1:0] lk_hidx;

  assign lk_hidx = HIDX_W'(hash_pick(lk_addr, hash_mode));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_group <= 1'b0;
      s1_bcast <= 1'b0;
      s1_bcen  <= 1'b0;
    end else begin
      s1_valid <= lk_valid;
      s1_group <= lk_valid && lk_addr[0];
      s1_bcast <= lk_valid && (&lk_addr);
      s1_bcen  <= bcast_en;
    end
  end

  rxf_entry_bank #(
    .N_ENTRIES    (N_ENTRIES),
    .POOL_W       (POOL_W),
    .POOL_LSB     (POOL_LSB),
    .VALID_BIT    (VALID_BIT),
    .STATION_ADDR (STATION_ADDR)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .we       (ent_we),
    .widx     (ent_sel),
    .whi      (ent_hi),
    .wdata    (ent_data),
    .lk_valid (lk_valid),
    .lk_addr  (lk_addr),
    .s1_hit   (s1_hit),
    .s1_idx   (s1_idx),
    .s1_pool  (s1_pool)
  );

  rxf_hash_table #(
    .WORDS  (HT_WORDS),
    .WORD_W (HT_WORD_W)
  ) u_hash (
    .clk     (clk),
    .rst     (rst),
    .set_en  (hash_we),
    .set_vec (HIDX_W'(hash_vec)),
    .rd_en   (lk_valid),
    .rd_vec  (lk_hidx),
    .rd_bit  (s1_hash_bit)
  );

  rxf_decide #(
    .IDX_W  (IDX_W),
    .POOL_W (POOL_W)
  ) u_decide (
    .clk         (clk),
    .rst         (rst),
    .s1_valid    (s1_valid),
    .s1_group    (s1_group),
    .s1_bcast    (s1_bcast),
    .s1_bcen     (s1_bcen),
    .s1_hash_bit (s1_hash_bit),
    .s1_hit      (s1_hit),
    .s1_idx      (s1_idx),
    .s1_pool     (s1_pool),
    .res_valid   (res_valid),
    .res_accept  (res_accept),
    .res_hit     (res_hit),
    .res_index   (res_index),
    .res_pool    (res_pool)
  );

  AST_BCAST_GATED: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && (&lk_addr) && !bcast_en) |=> ##1 (res_accept == res_hit)); // R9

endmodule

// File: tb/sim_rxf_addr_filter.sv
module sim_rxf_addr_filter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ent_we = 0, ent_hi = 0, hash_we = 0, bcast_en = 0, lk_valid = 0;
  logic [3:0]  ent_sel = '0;
  logic [31:0] ent_data = '0;
  logic [11:0] hash_vec = '0;
  logic [1:0]  hash_mode = '0;
  logic [47:0] lk_addr = '0;

  logic       v0, a0, h0, v1, a1, h1;
  logic [3:0] i0, i1;
  logic [5:0] p0, p1;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rxf_addr_filter u0 (
    .clk(clk), .rst(rst), .ent_we(ent_we), .ent_sel(ent_sel), .ent_hi(ent_hi),
    .ent_data(ent_data), .hash_we(hash_we), .hash_vec(hash_vec), .hash_mode(hash_mode),
    .bcast_en(bcast_en), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .res_valid(v0), .res_accept(a0), .res_hit(h0), .res_index(i0), .res_pool(p0));

  rxf_addr_filter #(.STATION_ADDR(48'h0)) u1 (
    .clk(clk), .rst(rst), .ent_we(ent_we), .ent_sel(ent_sel), .ent_hi(ent_hi),
    .ent_data(ent_data), .hash_we(hash_we), .hash_vec(hash_vec), .hash_mode(hash_mode),
    .bcast_en(bcast_en), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .res_valid(v1), .res_accept(a1), .res_hit(h1), .res_index(i1), .res_pool(p1));

  task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic put_entry(int idx, logic hi, logic [31:0] d);
    @(negedge clk);
    ent_we = 1; ent_sel = 4'(idx); ent_hi = hi; ent_data = d;
    @(negedge clk);
    ent_we = 0;
  endtask

  task automatic set_hash(logic [11:0] v);
    @(negedge clk);
    hash_we = 1; hash_vec = v;
    @(negedge clk);
    hash_we = 0;
  endtask

  // Present, then sample two rising edges later (R10).
  task automatic lookup(logic [47:0] a);
    @(negedge clk);
    lk_valid = 1; lk_addr = a;
    @(negedge clk);
    lk_valid = 0;
    check("R10", "res_valid after one edge", {63'd0, v0}, 64'd0);
    @(negedge clk);
    check("R10", "res_valid after two edges", {63'd0, v0}, 64'd1);
  endtask

  task automatic expect0(string req, logic acc, logic hit, int idx, int pool);
    check(req, "accept", {63'd0, a0}, {63'd0, acc});
    check(req, "hit", {63'd0, h0}, {63'd0, hit});
    check(req, "index", {60'd0, i0}, 64'(idx));
    check(req, "pool", {58'd0, p0}, 64'(pool));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "res_valid in reset", {63'd0, v0}, 64'd0);
    check("R11", "accept idle", {63'd0, a0}, 64'd0);
    rst = 0;
    lookup(48'h5544_3322_1102);
    expect0("R1", 1, 1, 0, 0);
    check("R1", "u1 zero station hit", {63'd0, h1}, 64'd0);
    lookup(48'h0);
    check("R1", "u1 zero addr accept", {63'd0, a1}, 64'd0);
    for (int m = 0; m < 4; m++) begin
      hash_mode = 2'(m);
      lookup(48'hFFFF_0000_0001);
      expect0("R1", 0, 0, 0, 0);
    end
    hash_mode = 0;
  endtask

  task automatic t_exact();
    put_entry(3, 0, 32'hDDCC_BBAA);
    put_entry(3, 1, 32'h0014_F0EE);
    lookup(48'hF0EE_DDCC_BBAA);
    expect0("R3", 0, 0, 0, 0);
    put_entry(3, 1, 32'h8014_F0EE);
    lookup(48'hF0EE_DDCC_BBAA);
    expect0("R4", 1, 1, 3, 5);
    lookup(48'hAABB_CCDD_EEF0);
    expect0("R2", 0, 0, 0, 0);
    lookup(48'hF0EE_DDCC_BBAB);
    expect0("R2", 0, 0, 0, 0);
  endtask

  task automatic t_priority();
    put_entry(7, 0, 32'hDDCC_BBAA);
    put_entry(7, 1, 32'h8024_F0EE);
    lookup(48'hF0EE_DDCC_BBAA);
    expect0("R5", 1, 1, 3, 5);
    put_entry(3, 1, 32'h0014_F0EE);
    lookup(48'hF0EE_DDCC_BBAA);
    expect0("R5", 1, 1, 7, 9);
  endtask

  task automatic t_hash_modes();
    hash_mode = 0;
    set_hash(12'hCDA);
    lookup(48'hCDAB_0000_0001);
    expect0("R6", 1, 0, 0, 0);
    lookup(48'hCDAB_0000_0000);
    expect0("R8", 0, 0, 0, 0);
    hash_mode = 1;
    lookup(48'hCDAB_0000_0001);
    expect0("R6", 0, 0, 0, 0);
    set_hash(12'h9B5);
    lookup(48'hCDAB_0000_0001);
    expect0("R6", 1, 0, 0, 0);
    hash_mode = 3;
    set_hash(12'hDAB);
    lookup(48'hCDAB_0000_0001);
    expect0("R6", 1, 0, 0, 0);
    hash_mode = 2;
    lookup(48'hCDAB_0000_0001);
    expect0("R6", 0, 0, 0, 0);
  endtask

  task automatic t_hash_or();
    hash_mode = 0;
    lookup(48'hCDB0_0000_0001);
    expect0("R7", 0, 0, 0, 0);
    set_hash(12'hCDB);
    lookup(48'hCDB0_0000_0001);
    expect0("R7", 1, 0, 0, 0);
    lookup(48'hCDA0_0000_0001);
    expect0("R7", 1, 0, 0, 0);
    lookup(48'hCDC0_0000_0001);
    expect0("R7", 0, 0, 0, 0);
  endtask

  task automatic t_broadcast();
    hash_mode = 0;
    set_hash(12'hFFF);
    bcast_en = 0;
    lookup(48'hFFFF_FFFF_FFFF);
    expect0("R9", 0, 0, 0, 0);
    bcast_en = 1;
    lookup(48'hFFFF_FFFF_FFFF);
    expect0("R9", 1, 0, 0, 0);
    bcast_en = 0;
    put_entry(9, 0, 32'hFFFF_FFFF);
    put_entry(9, 1, 32'h8000_FFFF);
    lookup(48'hFFFF_FFFF_FFFF);
    expect0("R9", 1, 1, 9, 0);
  endtask

  initial begin
    t_reset();
    t_exact();
    t_priority();
    t_hash_modes();
    t_hash_or();
    t_broadcast();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule